// File: doc/BRIEF.md
# AC Line Timeslot Tracker

This block numbers the beam timeslots defined by the AC mains. The three mains phases cross zero six times per period. Each crossing reaches the block as a one-cycle fiducial strobe, at 360 Hz. On every strobe the block steps a slot index through 1 to 6. Because the strobes are locked to the mains, a given slot number always stands for the same phase configuration of the mains in every period.

A sync strobe, taken from the rising zero crossing of the reference phase, realigns the count so that the next fiducial lands on slot 1. A two-bit pair select picks which pair of opposite slots counts as active: 1 with 4, 2 with 5, or 3 with 6. The registered active flag then marks fiducials that open an active slot. A watchdog on the fiducial stream raises a lost-lock flag when no strobe arrives within a programmable number of clock cycles.

Top module: `ac_slot_tracker`

## Requirements
- R1: After reset, slot_o is 6, active_o is 0 and lost_lock_o is 0, so the first fiducial lands on slot 1.
- R2: A fiducial sampled on a clock edge advances slot_o by one from slots 1 to 5, and the new value is visible after that edge.
- R3: A fiducial taken while slot_o is 6 sets slot_o to 1. slot_o never leaves the range 1 to 6.
- R4: On an edge without a fiducial, slot_o and active_o keep their values, whatever sync_i and pair_sel_i do.
- R5: A sync_i pulse between fiducials is held until the next fiducial. That fiducial sets slot_o to 1, and later fiducials count on from 1 with no further realignment.
- R6: When sync_i and fid_i are high in the same cycle, that fiducial sets slot_o to 1.
- R7: On each fiducial, active_o becomes 1 only if the new slot is in the selected pair. pair_sel_i codes: 0 selects slots 1 and 4, 1 selects 2 and 5, 2 selects 3 and 6, and 3 selects no slot.
- R8: A change of pair_sel_i between fiducials does not change active_o before the next fiducial.
- R9: With timeout_i = N > 0, lost_lock_o rises on the N-th consecutive clock edge without a fiducial, counted from the last fiducial or from reset. It stays high until a fiducial arrives.
- R10: A fiducial clears lost_lock_o on the edge that samples it.
- R11: With timeout_i = 0 the watchdog is off and lost_lock_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fid_i | input | 1 | One-cycle fiducial strobe, one per phase zero crossing |
| sync_i | input | 1 | One-cycle realign strobe from the reference phase's rising crossing |
| pair_sel_i | input | 2 | Active pair code (0: 1/4, 1: 2/5, 2: 3/6, 3: none) |
| timeout_i | input | TO_W (20) | Watchdog limit in clock cycles, 0 disables it |
| slot_o | output | 3 | Current slot number, 1 to 6 |
| active_o | output | 1 | Current slot belongs to the selected pair |
| lost_lock_o | output | 1 | No fiducial within the timeout |

## Verification
Two functions can fall in the same cycle: a sync strobe and a fiducial. The bench drives them together while the count sits in mid-cycle and expects slot 1 after that edge, with the active flag worked out for slot 1. A second case runs the watchdog limit out on the same edge that samples a late fiducial. Here the fiducial must win, so lost_lock_o stays low while the slot advances.

// File: rtl/ac_slot_pkg.sv
package ac_slot_pkg;
  localparam int unsigned NUM_SLOTS = 6;
  localparam int unsigned HALF      = NUM_SLOTS / 2;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS + 1);
  localparam int unsigned PAIR_W    = $clog2(HALF + 1);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [PAIR_W-1:0] pair_t;

  localparam slot_t SLOT_FIRST = slot_t'(1);
  localparam slot_t SLOT_LAST  = slot_t'(NUM_SLOTS);
endpackage

// File: rtl/ac_slot_counter.sv
module ac_slot_counter
  import ac_slot_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fid_i,
  input  logic  sync_i,
  output slot_t slot_o,
  output slot_t slot_nxt_o
);
  slot_t slot_q;
  logic  pend_q;
  logic  take_sync;

  assign take_sync = sync_i | pend_q;

  always_comb begin
    if (take_sync || slot_q == SLOT_LAST) slot_nxt_o = SLOT_FIRST;
    else                                   slot_nxt_o = slot_q + slot_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SLOT_LAST;
      pend_q <= 1'b0;
    end else if (fid_i) begin
      slot_q <= slot_nxt_o;
      pend_q <= 1'b0;
    end else if (sync_i) begin
      pend_q <= 1'b1;
    end
  end

  assign slot_o = slot_q;

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q >= SLOT_FIRST && slot_q <= SLOT_LAST); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fid_i |=> $stable(slot_q)); // R4
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fid_i && !sync_i && !pend_q && slot_q == SLOT_LAST) |=> slot_q == SLOT_FIRST); // R3
  AST_SYNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fid_i && (sync_i || pend_q)) |=> slot_q == SLOT_FIRST); // R5
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fid_i |=> !pend_q); // R5
endmodule

// File: rtl/ac_slot_active.sv
module ac_slot_active
  import ac_slot_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fid_i,
  input  slot_t slot_nxt_i,
  input  pair_t pair_sel_i,
  output logic  active_o
);
  logic [NUM_SLOTS-1:0] hit;
  logic active_q;

  for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
    localparam pair_t CODE = pair_t'((s - 1) % HALF);
    assign hit[s-1] = (slot_nxt_i == slot_t'(s)) && (pair_sel_i == CODE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    active_q <= 1'b0;
    else if (fid_i) active_q <= |hit;
  end

  assign active_o = active_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fid_i |=> $stable(active_q)); // R8
  AST_NONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fid_i && pair_sel_i == pair_t'(HALF)) |=> !active_q); // R7
endmodule

// File: rtl/ac_lock_monitor.sv
module ac_lock_monitor #(
  parameter int unsigned TO_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fid_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            lost_o
);
  logic [TO_W-1:0] gap_q;
  logic [TO_W:0]   gap_inc;
  logic            expire;
  logic            lost_q;

  assign gap_inc = {1'b0, gap_q} + {{TO_W{1'b0}}, 1'b1};
  assign expire  = (timeout_i != '0) && (gap_inc >= {1'b0, timeout_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      lost_q <= 1'b0;
    end else if (fid_i) begin
      gap_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (gap_q != '1) gap_q <= gap_inc[TO_W-1:0];
      if (expire)      lost_q <= 1'b1;
    end
  end

  assign lost_o = lost_q;

  AST_LOST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fid_i |=> !lost_q); // R10
  AST_LOST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_q && !fid_i) |=> lost_q); // R9
  AST_WDOG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i == '0 && !lost_q) |=> !lost_q); // R11
endmodule

// File: rtl/ac_slot_tracker.sv
module ac_slot_tracker
  import ac_slot_pkg::*;
#(
  parameter int unsigned TO_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fid_i,
  input  logic            sync_i,
  input  logic [1:0]      pair_sel_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic [2:0]      slot_o,
  output logic            active_o,
  output logic            lost_lock_o
);
  slot_t slot_cur;
  slot_t slot_nxt;

  ac_slot_counter u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fid_i      (fid_i),
    .sync_i     (sync_i),
    .slot_o     (slot_cur),
    .slot_nxt_o (slot_nxt)
  );

  ac_slot_active u_active (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fid_i      (fid_i),
    .slot_nxt_i (slot_nxt),
    .pair_sel_i (pair_t'(pair_sel_i)),
    .active_o   (active_o)
  );

  ac_lock_monitor #(.TO_W(TO_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fid_i     (fid_i),
    .timeout_i (timeout_i),
    .lost_o    (lost_lock_o)
  );

  assign slot_o = 3'(slot_cur);

  AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fid_i && !sync_i && slot_o != 3'd6) |=> (slot_o == 3'd1 || slot_o == $past(slot_o) + 3'd1)); // R2
endmodule

// File: tb/ac_slot_tracker_bench.sv
module ac_slot_tracker_bench;
  localparam int TO_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fid = 1'b0, sync = 1'b0;
  logic [1:0] pair_sel = 2'd0;
  logic [TO_W-1:0] timeout = '0;
  logic [2:0] slot;
  logic active, lost;

  int n_chk = 0, n_err = 0;
  int exp_slot = 6;
  bit pend = 0;

  always #4 clk = ~clk;

  ac_slot_tracker #(.TO_W(TO_W)) u_ac_slot_tracker (
    .clk_i(clk), .rst_ni(rst_n), .fid_i(fid), .sync_i(sync),
    .pair_sel_i(pair_sel), .timeout_i(timeout),
    .slot_o(slot), .active_o(active), .lost_lock_o(lost)
  );

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_act(input int s, input int p);
    if (p == 3) return 0;
    return (s == p + 1 || s == p + 4) ? 1 : 0;
  endfunction

  // One fiducial, optionally with a coincident sync; sample after the edge.
  task automatic step(input bit with_sync);
    @(negedge clk);
    fid = 1'b1; sync = with_sync;
    @(negedge clk);
    fid = 1'b0; sync = 1'b0;
    exp_slot = (pend || with_sync) ? 1 : (exp_slot == 6 ? 1 : exp_slot + 1);
    pend = 0;
  endtask

  task automatic t_reset;
    chk("R1 slot", slot, 6);
    chk("R1 active", active, 0);
    chk("R1 lost", lost, 0);
  endtask

  task automatic t_advance;
    pair_sel = 2'd0;
    for (int i = 0; i < 13; i++) begin
      step(0);
      chk(exp_slot == 1 ? "R3 wrap" : "R2 advance", slot, exp_slot);
      chk("R7 active p0", active, exp_act(exp_slot, 0));
    end
  endtask

  task automatic t_hold;
    int s0, a0;
    s0 = slot; a0 = active;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      pair_sel = 2'(i);
    end
    chk("R4 slot hold", slot, s0);
    chk("R8 active hold", active, a0);
    pair_sel = 2'd0;
  endtask

  task automatic t_sync_between;
    while (exp_slot != 3) step(0);
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0; pend = 1;
    chk("R5 no move on sync", slot, 3);
    repeat (3) @(negedge clk);
    step(0);
    chk("R5 realign", slot, 1);
    chk("R5 active at 1", active, 1);
    step(0);
    chk("R5 continue", slot, 2);
    step(0);
    chk("R5 no repeat", slot, 3);
  endtask

  task automatic t_sync_same;
    while (exp_slot != 4) step(0);
    pair_sel = 2'd1;
    step(1);
    chk("R6 coincident sync", slot, 1);
    chk("R6 active p1 at 1", active, 0);
    step(0);
    chk("R6 after", slot, 2);
    chk("R7 active p1 at 2", active, 1);
  endtask

  task automatic t_pairs;
    for (int p = 0; p < 4; p++) begin
      pair_sel = 2'(p);
      for (int i = 0; i < 6; i++) begin
        step(0);
        chk($sformatf("R7 pair %0d slot %0d", p, exp_slot), active, exp_act(exp_slot, p));
      end
    end
  endtask

  task automatic t_pair_change;
    pair_sel = 2'd2;
    while (exp_slot != 3) step(0);
    chk("R7 p2 slot3", active, 1);
    @(negedge clk); pair_sel = 2'd3;
    @(negedge clk);
    chk("R8 change ignored", active, 1);
    step(0);
    chk("R8 applied at fid", active, 0);
  endtask

  task automatic t_lost;
    timeout = 20'd5;
    step(0);
    repeat (4) @(negedge clk);
    chk("R9 not yet", lost, 0);
    @(negedge clk);
    chk("R9 expired", lost, 1);
    repeat (3) @(negedge clk);
    chk("R9 sticky", lost, 1);
    step(0);
    chk("R10 cleared", lost, 0);
    chk("R10 slot advanced", slot, exp_slot);
    // late fiducial on the very edge the limit runs out
    repeat (3) @(negedge clk);
    step(0);
    chk("R10 fid wins over expiry", lost, 0);
    chk("R2 slot on limit edge", slot, exp_slot);
  endtask

  task automatic t_off;
    timeout = '0;
    step(0);
    repeat (40) @(negedge clk);
    chk("R11 disabled", lost, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_advance();
    t_hold();
    t_sync_between();
    t_sync_same();
    t_pairs();
    t_pair_change();
    t_lost();
    t_off();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule